// File: doc/BRIEF.md
# Character LCD Power-Up Sequencer

This block brings a parallel 8-bit character LCD controller from power-up to a configured, blank, cursor-on state. After reset it waits a fixed power-settle time, then sends a fixed list of nine instruction bytes to a lower-level bus cycle engine. It sends each byte with a valid/ready handshake and always marks it as an instruction (register select low). The early steps are separated by fixed timed gaps because the controller's busy flag cannot be trusted yet. Every later step first asks the bus engine to poll the busy flag and waits until the flag reads clear.

The controller's state machine has four states. `S_DELAY` counts a timed wait: the power-settle time after reset, or a gap after one of the first two commands. `S_ISSUE` presents the current command. `S_POLL` requests busy-flag reads. `S_DONE` is terminal.
The transitions are:
- `S_DELAY` -> `S_ISSUE` when the wait counter reaches zero.
- `S_ISSUE` -> `S_DELAY` on acceptance of step 0 or step 1.
- `S_ISSUE` -> `S_POLL` on acceptance of steps 2 to 7.
- `S_ISSUE` -> `S_DONE` on acceptance of step 8.
- `S_POLL` -> `S_ISSUE` when a poll is accepted and the busy flag reads clear.
- Reset forces `S_DELAY` from any state.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is high, `wr_valid`, `poll_req` and `done` are low. After reset is released, the first command appears with `wr_valid` high on exactly the `PWRUP_CYC`-th rising edge, and not before.
- R2: `rs` is 0 in every cycle.
- R3: The command bytes are presented in this order: 0x38, 0x38, 0x38, 0x38, 0x08, 0x01, 0x06, 0x0F, 0x01. In 0x38, bit 4 selects the 8-bit bus, bit 3 selects two lines and bit 2 clear selects 5x8 dots. In 0x06, bit 1 selects increment. In 0x0F, bits 2, 1 and 0 turn on the display, the cursor and blink.
- R4: After the first command is accepted, `wr_valid` and `poll_req` stay low for `GAP_A_CYC` cycles, and then the next command appears. After the second command, the same holds with `GAP_B_CYC`.
- R5: After each of commands three to eight is accepted, `poll_req` is high in the next cycle and `wr_valid` is low.
- R6: A poll completes only on a cycle where `poll_req` and `bus_ready` are both high, and `busy_flag` is sampled on that cycle. If the flag reads 1, or if `bus_ready` is low, polling continues. If the flag reads 0, the next command appears in the following cycle.
- R7: A command is accepted on a cycle where `wr_valid` and `bus_ready` are both high. Until then, `wr_valid` stays high and `cmd_byte` holds its value.
- R8: `done` is low until the last command is accepted. It goes high in the following cycle and stays high until reset. While `done` is high, `wr_valid` and `poll_req` are low.
- R9: A reset at any point, including mid-sequence, restarts the sequence from the power-settle wait and clears `done`.
- R10: `wr_valid` and `poll_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_ready | input | 1 | Bus engine accepts the current write or poll |
| busy_flag | input | 1 | Busy flag value, valid on an accepted poll |
| cmd_byte | output | 8 | Instruction byte to write |
| rs | output | 1 | Register select, always 0 (instruction) |
| wr_valid | output | 1 | Write request for `cmd_byte` |
| poll_req | output | 1 | Busy-flag read request |
| done | output | 1 | Sequence complete |

## Verification
The bench builds the block with `PWRUP_CYC` = 6, `GAP_A_CYC` = 4 and `GAP_B_CYC` = 3 clock cycles. The real millisecond values would cost hundreds of thousands of cycles, so these small values keep every timed edge within a few cycles. Checking those edges cycle-exactly would otherwise be out of reach. The three values also differ from one another, so a swapped or mis-selected gap shows up as an edge in the wrong cycle. The short waits leave room to vary the ready latency and the number of busy polls per step, and to reset in the middle of a gap.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

    // function-set fields
    localparam logic [7:0] FN_BASE  = 8'h20;
    localparam logic [7:0] FN_BUS8  = 8'h10;
    localparam logic [7:0] FN_LINE2 = 8'h08;
    localparam logic [7:0] FN_TALL  = 8'h04;

    // display-control fields
    localparam logic [7:0] DC_BASE  = 8'h08;
    localparam logic [7:0] DC_DISP  = 8'h04;
    localparam logic [7:0] DC_CURS  = 8'h02;
    localparam logic [7:0] DC_BLINK = 8'h01;

    // entry-mode fields
    localparam logic [7:0] EM_BASE  = 8'h04;
    localparam logic [7:0] EM_INC   = 8'h02;
    localparam logic [7:0] EM_SHIFT = 8'h01;

    localparam logic [7:0] CMD_CLEAR = 8'h01;

    localparam int N_STEPS = 9;
    localparam int STEP_W  = $clog2(N_STEPS);

    typedef enum logic [1:0] {
        WK_GAP_A,
        WK_GAP_B,
        WK_POLL,
        WK_END
    } wait_kind_e;

    typedef enum logic [1:0] {
        S_DELAY,
        S_ISSUE,
        S_POLL,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/lcd_step_rom.sv
module lcd_step_rom
    import lcd_init_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    output logic [7:0]        cmd,
    output wait_kind_e        kind
);

    localparam logic [7:0] FN_CMD  = FN_BASE | FN_BUS8 | FN_LINE2;
    localparam logic [7:0] DC_OFF  = DC_BASE;
    localparam logic [7:0] DC_ON   = DC_BASE | DC_DISP | DC_CURS | DC_BLINK;
    localparam logic [7:0] EM_CMD  = EM_BASE | EM_INC;

    always_comb begin
        cmd  = FN_CMD;
        kind = WK_POLL;
        unique case (idx)
            4'd0: begin cmd = FN_CMD;    kind = WK_GAP_A; end
            4'd1: begin cmd = FN_CMD;    kind = WK_GAP_B; end
            4'd2: begin cmd = FN_CMD;    kind = WK_POLL;  end
            4'd3: begin cmd = FN_CMD;    kind = WK_POLL;  end
            4'd4: begin cmd = DC_OFF;    kind = WK_POLL;  end
            4'd5: begin cmd = CMD_CLEAR; kind = WK_POLL;  end
            4'd6: begin cmd = EM_CMD;    kind = WK_POLL;  end
            4'd7: begin cmd = DC_ON;     kind = WK_POLL;  end
            4'd8: begin cmd = CMD_CLEAR; kind = WK_END;   end
            default: begin cmd = FN_CMD; kind = WK_END;   end
        endcase
    end

endmodule

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
    parameter int                 W       = 20,
    parameter logic [W-1:0]       RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= RST_VAL;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
    import lcd_init_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int PWRUP_CYC = CLK_HZ / 1000 * 15,
    parameter int GAP_A_CYC = CLK_HZ / 1000 * 5,
    parameter int GAP_B_CYC = CLK_HZ / 1_000_000 * 150
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_ready,
    input  logic       busy_flag,
    output logic [7:0] cmd_byte,
    output logic       rs,
    output logic       wr_valid,
    output logic       poll_req,
    output logic       done
);

    localparam int MAX_CYC = (PWRUP_CYC > GAP_A_CYC) ?
                             ((PWRUP_CYC > GAP_B_CYC) ? PWRUP_CYC : GAP_B_CYC) :
                             ((GAP_A_CYC > GAP_B_CYC) ? GAP_A_CYC : GAP_B_CYC);
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PWR_LD   = CNT_W'(PWRUP_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_A_LD = CNT_W'(GAP_A_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_B_LD = CNT_W'(GAP_B_CYC - 1);

    seq_state_e        state, state_nx;
    logic [STEP_W-1:0] idx;
    logic [7:0]        rom_cmd;
    wait_kind_e        rom_kind;
    logic              accept;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;

    lcd_step_rom u_rom (
        .idx  (idx),
        .cmd  (rom_cmd),
        .kind (rom_kind)
    );

    lcd_wait_timer #(.W(CNT_W), .RST_VAL(PWR_LD)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign accept   = (state == S_ISSUE) && bus_ready;
    assign tmr_load = accept && (rom_kind == WK_GAP_A || rom_kind == WK_GAP_B);
    assign tmr_val  = (rom_kind == WK_GAP_A) ? GAP_A_LD : GAP_B_LD;

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_DELAY: if (tmr_zero) state_nx = S_ISSUE;
            S_ISSUE: begin
                if (bus_ready) begin
                    unique case (rom_kind)
                        WK_GAP_A, WK_GAP_B: state_nx = S_DELAY;
                        WK_POLL:            state_nx = S_POLL;
                        WK_END:             state_nx = S_DONE;
                    endcase
                end
            end
            S_POLL:  if (bus_ready && !busy_flag) state_nx = S_ISSUE;
            S_DONE:  state_nx = S_DONE;
        endcase
    end

    // state and step registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_DELAY;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (accept && rom_kind != WK_END)
                idx <= idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        cmd_byte = rom_cmd;
        rs       = 1'b0;
        wr_valid = 1'b0;
        poll_req = 1'b0;
        done     = 1'b0;
        unique case (state)
            S_DELAY: ;
            S_ISSUE: wr_valid = 1'b1;
            S_POLL:  poll_req = 1'b1;
            S_DONE:  done     = 1'b1;
        endcase
    end

endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_ready,
    input logic       busy_flag,
    input logic [7:0] cmd_byte,
    input logic       rs,
    input logic       wr_valid,
    input logic       poll_req,
    input logic       done
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wr_valid && !poll_req && !done));

    // R2
    rs_low_chk: assert property (@(posedge clk) disable iff (rst) rs == 1'b0);

    // R7
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !bus_ready) |=> (wr_valid && $stable(cmd_byte)));

    // R6
    poll_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (poll_req && (!bus_ready || busy_flag)) |=> poll_req);

    // R6
    poll_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (poll_req && bus_ready && !busy_flag) |=> wr_valid);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!wr_valid && !poll_req));

    // R10
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && poll_req));

endmodule

bind lcd_init_seq lcd_init_seq_chk u_chk (.*);

// File: tb/tb_lcd_init_seq.sv
module tb_lcd_init_seq;

    localparam int P  = 6;
    localparam int GA = 4;
    localparam int GB = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_ready = 1'b0;
    logic       busy_flag = 1'b0;
    logic [7:0] cmd_byte;
    logic       rs, wr_valid, poll_req, done;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    lcd_init_seq #(.PWRUP_CYC(P), .GAP_A_CYC(GA), .GAP_B_CYC(GB)) dut (
        .clk(clk), .rst(rst), .bus_ready(bus_ready), .busy_flag(busy_flag),
        .cmd_byte(cmd_byte), .rs(rs), .wr_valid(wr_valid),
        .poll_req(poll_req), .done(done)
    );

    // {byte, ready latency, wait kind (1 gapA, 2 gapB, 0 poll, 3 end), busy polls}
    localparam logic [17:0] STEPS [9] = '{
        {8'h38, 4'd0, 2'd1, 4'd0},
        {8'h38, 4'd2, 2'd2, 4'd0},
        {8'h38, 4'd1, 2'd0, 4'd0},
        {8'h38, 4'd0, 2'd0, 4'd3},
        {8'h08, 4'd3, 2'd0, 4'd1},
        {8'h01, 4'd0, 2'd0, 4'd2},
        {8'h06, 4'd1, 2'd0, 4'd0},
        {8'h0F, 4'd2, 2'd0, 4'd1},
        {8'h01, 4'd1, 2'd3, 4'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        chk(rs == 1'b0, "R2 rs", int'(rs), 0);
        chk(!(wr_valid && poll_req), "R10 exclusive", int'({wr_valid, poll_req}), 0);
    endtask

    task automatic do_reset();
        rst = 1'b1; bus_ready = 1'b0; busy_flag = 1'b0;
        tick(); tick();
        chk(!wr_valid && !poll_req && !done, "R1 reset state",
            int'({wr_valid, poll_req, done}), 0);
        rst = 1'b0;
    endtask

    task automatic power_wait();
        for (int k = 1; k < P; k++) begin
            tick();
            chk(!wr_valid, "R1 early write", int'(wr_valid), 0);
        end
        tick();
        chk(wr_valid, "R1 first write", int'(wr_valid), 1);
        chk(cmd_byte == 8'h38, "R3 first byte", int'(cmd_byte), 8'h38);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();
        power_wait();
        for (int i = 0; i < 9; i++) begin
            logic [7:0] eb;
            int hold, kind, bp, gap;
            eb   = STEPS[i][17:10];
            hold = int'(STEPS[i][9:6]);
            kind = int'(STEPS[i][5:4]);
            bp   = int'(STEPS[i][3:0]);
            chk(wr_valid && cmd_byte == eb, "R3 order", int'(cmd_byte), int'(eb));
            chk(!done, "R8 early done", int'(done), 0);
            bus_ready = 1'b0;
            for (int h = 0; h < hold; h++) begin
                tick();
                chk(wr_valid && cmd_byte == eb, "R7 hold", int'(cmd_byte), int'(eb));
            end
            bus_ready = 1'b1;
            tick();
            bus_ready = 1'b0;
            if (kind == 1 || kind == 2) begin
                gap = (kind == 1) ? GA : GB;
                // busy_flag is driven during the gap and must not matter
                busy_flag = 1'b1;
                chk(!wr_valid && !poll_req, "R4 gap", int'({wr_valid, poll_req}), 0);
                for (int k = 2; k <= gap; k++) begin
                    tick();
                    chk(!wr_valid && !poll_req, "R4 gap", int'({wr_valid, poll_req}), 0);
                end
                busy_flag = 1'b0;
                tick();
                chk(wr_valid, "R4 gap end", int'(wr_valid), 1);
            end else if (kind == 0) begin
                chk(poll_req && !wr_valid, "R5 poll start", int'({poll_req, wr_valid}), 2);
                busy_flag = 1'b1; bus_ready = 1'b1;
                for (int b = 0; b < bp; b++) begin
                    tick();
                    chk(poll_req && !wr_valid, "R6 busy keeps polling", int'(poll_req), 1);
                end
                bus_ready = 1'b0; busy_flag = 1'b0;
                tick();
                chk(poll_req, "R6 no ready keeps polling", int'(poll_req), 1);
                bus_ready = 1'b1;
                tick();
                bus_ready = 1'b0;
                chk(wr_valid && !poll_req, "R6 clear releases", int'({wr_valid, poll_req}), 2);
            end else begin
                chk(done && !wr_valid, "R8 done after last", int'({done, wr_valid}), 2);
            end
        end

        for (int k = 0; k < 6; k++) begin
            bus_ready = 1'b1; busy_flag = k[0];
            tick();
            chk(done && !wr_valid && !poll_req, "R8 done sticky",
                int'({done, wr_valid, poll_req}), 4);
        end

        // R9: reset after done clears it and restarts
        do_reset();
        power_wait();
        bus_ready = 1'b1;
        tick();
        bus_ready = 1'b0;
        tick();
        // R9: reset in the middle of the first gap
        rst = 1'b1;
        tick();
        chk(!wr_valid && !done && !poll_req, "R9 mid reset",
            int'({wr_valid, poll_req, done}), 0);
        rst = 1'b0;
        power_wait();
        chk(!done, "R9 done cleared", int'(done), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule